// File: doc/BRIEF.md
# Two-Stage Masked Pattern Trigger with Delayed Gate

This block watches a parallel input bus, 28 pins wide by default, for two patterns that must appear in order. Each pattern stage has two words. A level word gives the value each pin must show. A mask word says which pins matter. A pin whose mask bit is 0 is ignored. When the first pattern is seen, a sticky flag rises and the second stage becomes live. The second stage can only set its own sticky flag on a later cycle. A trigger enable input sits between the bus and both pattern comparators, so no trigger can fire while it is low.

All six configuration words are filled from a single serial stream. This covers two words for each trigger stage and two for the gate condition. Bits are shifted into a common shift register, and a load strobe with a select code copies the register into one word. The second-stage words are loaded into a holding copy. The comparator only takes that copy at the moment the first stage fires, so the second-stage words can be prepared ahead of time without disturbing a match that is in progress.

A separate masked condition drives a delayed gate. The gate output stays low until the condition has held for a fixed number of consecutive cycles, and it drops as soon as the condition fails. A sticky status reports that the gate was open at some point. One synchronous clear resets all flags and the gate timing, and re-arms the first stage.

Top module: `dual_pattern_trigger`

## Requirements
- R1: After reset, `word1Hit`, `word2Hit`, `gateOut` and `gateSeen` are all 0. All six configuration words reset to 0.
- R2: While `cfgShift` is high, the shift register moves left on each clock and `cfgBit` enters at bit 0. The first bit sent ends in bit W-1. A cycle with `cfgLoad` high copies the shift register, as it stood before that edge, into the word chosen by `cfgSel`. The codes are: 0 = stage-1 level, 1 = stage-1 mask, 2 = stage-2 level (holding copy), 3 = stage-2 mask (holding copy), 4 = gate level, 5 = gate mask. Codes 6 and 7 change no word.
- R3: A stage matches when `((busIn ^ level) & mask) == 0` and `trigEn` is high. A stage-1 match sampled at a clock edge sets `word1Hit` after that edge.
- R4: While `trigEn` is low, neither `word1Hit` nor `word2Hit` can rise, whatever `busIn` shows.
- R5: A stage-2 match sets `word2Hit` only if `word1Hit` was already high at that edge. A bus value that matches stage 2 while `word1Hit` is low leaves `word2Hit` at 0.
- R6: The stage-2 comparator uses the holding words as they stood at the edge where `word1Hit` rose. Loads to codes 2 and 3 after that edge have no effect until stage 1 fires again after a clear.
- R7: `word1Hit` and `word2Hit` stay high until `clear`. After a clear, stage 1 can fire again.
- R8: The gate condition is `((busIn ^ gateLevel) & gateMask) == 0`, independent of `trigEn`. `gateOut` rises after GATE_DLY consecutive edges with the condition true. It falls after the first edge where the condition is false.
- R9: `gateSeen` is high whenever `gateOut` is high, and it then stays high until `clear`.
- R10: `clear` takes priority over any match in the same cycle. After that edge `word1Hit`, `word2Hit`, `gateOut` and `gateSeen` are all 0, and the gate delay restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busIn | input | W | Observed pin bus |
| trigEn | input | 1 | Enables the bus into both trigger comparators |
| cfgBit | input | 1 | Serial configuration data |
| cfgShift | input | 1 | Shift `cfgBit` into the configuration register |
| cfgLoad | input | 1 | Copy the configuration register into the selected word |
| cfgSel | input | 3 | Word select code for `cfgLoad` |
| clear | input | 1 | Clear flags and gate state, re-arm stage 1 |
| word1Hit | output | 1 | Sticky: first pattern occurred |
| word2Hit | output | 1 | Sticky: second pattern occurred after the first |
| gateOut | output | 1 | Delayed gate |
| gateSeen | output | 1 | Sticky: gate was open |

## Verification
A corrupted configuration word or holding copy shows up as a flag that rises on the wrong bus value. This is visible one cycle after the offending bus value, so every cycle the bench compares the flags against a model built from the requirements. A gate counter that is off by one moves the rising edge of `gateOut` by one cycle, and the gate tests time that edge exactly. A lost staging step makes `word2Hit` follow words loaded after stage 1 fired. Directed sequences load new holding words at that point and then present both the old and the new pattern.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_WORDS = 6;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_LVL1  = 3'd0,
    SEL_MSK1  = 3'd1,
    SEL_LVL2  = 3'd2,
    SEL_MSK2  = 3'd3,
    SEL_GLVL  = 3'd4,
    SEL_GMSK  = 3'd5
  } word_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] ldWord;   // one-hot word write enables
    logic                 promote;  // copy stage-2 holding words to active
    logic                 clrGate;  // restart gate delay
  } ctl_t;
endpackage

// File: rtl/trig_match.sv
module trig_match #(
  parameter int W = 28
) (
  input  logic [W-1:0] busIn,
  input  logic         en,
  input  logic [W-1:0] level,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] diffBits;

  assign diffBits = (busIn ^ level) & mask;
  assign hit      = en && (diffBits == '0);
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int W        = 28,
  parameter int GATE_DLY = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] busIn,
  input  logic         trigEn,
  input  logic         cfgBit,
  input  logic         cfgShift,
  input  ctl_t         ctl,
  output logic         hit1,
  output logic         hit2,
  output logic         gateOut
);
  localparam int CW = $clog2(GATE_DLY + 1);
  localparam logic [CW-1:0] DLY_MAX = CW'(GATE_DLY);
  localparam int N_CMP = 3;

  logic [W-1:0] shiftReg;
  logic [W-1:0] wordQ [NUM_WORDS];
  logic [W-1:0] act2Level, act2Mask;
  logic [CW-1:0] gateCnt;
  logic gateCond;

  // serial configuration register, MSB first
  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (cfgShift) shiftReg <= {shiftReg[W-2:0], cfgBit};
  end

  // configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) wordQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (ctl.ldWord[i]) wordQ[i] <= shiftReg;
    end
  end

  // active stage-2 words, taken from holding words when stage 1 fires
  always_ff @(posedge clk) begin
    if (rst) begin
      act2Level <= '0;
      act2Mask  <= '0;
    end else if (ctl.promote) begin
      act2Level <= wordQ[SEL_LVL2];
      act2Mask  <= wordQ[SEL_MSK2];
    end
  end

  // three comparators: stage 1, stage 2, gate condition
  logic [W-1:0] cmpLevel [N_CMP];
  logic [W-1:0] cmpMask  [N_CMP];
  logic         cmpEn    [N_CMP];
  logic         cmpHit   [N_CMP];

  always_comb begin
    cmpLevel[0] = wordQ[SEL_LVL1];
    cmpMask[0]  = wordQ[SEL_MSK1];
    cmpEn[0]    = trigEn;
    cmpLevel[1] = act2Level;
    cmpMask[1]  = act2Mask;
    cmpEn[1]    = trigEn;
    cmpLevel[2] = wordQ[SEL_GLVL];
    cmpMask[2]  = wordQ[SEL_GMSK];
    cmpEn[2]    = 1'b1;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    trig_match #(.W(W)) u_match (
      .busIn (busIn),
      .en    (cmpEn[g]),
      .level (cmpLevel[g]),
      .mask  (cmpMask[g]),
      .hit   (cmpHit[g])
    );
  end

  assign hit1     = cmpHit[0];
  assign hit2     = cmpHit[1];
  assign gateCond = cmpHit[2];

  // saturating run-length counter for the delayed gate
  always_ff @(posedge clk) begin
    if (rst || ctl.clrGate || !gateCond) gateCnt <= '0;
    else if (gateCnt != DLY_MAX) gateCnt <= gateCnt + 1'b1;
  end

  assign gateOut = (gateCnt == DLY_MAX);

  // R4
  no_hit_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !trigEn |-> (!hit1 && !hit2));

  // R6
  act2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.promote |=> ($stable(act2Level) && $stable(act2Mask)));

  // R8
  gate_needs_cond_chk: assert property (@(posedge clk) disable iff (rst)
    gateOut |-> $past(gateCond));

  // R8
  gate_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (gateOut && gateCond && !ctl.clrGate) |=> gateOut);
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             clear,
  input  logic             hit1,
  input  logic             hit2,
  input  logic             gateOut,
  output ctl_t             ctl,
  output logic             word1Hit,
  output logic             word2Hit,
  output logic             gateSeen
);
  logic flag1Q, flag2Q, seenQ;
  logic fire1, fire2;

  always_comb begin
    ctl.ldWord = '0;
    if (cfgLoad && (int'(cfgSel) < NUM_WORDS))
      ctl.ldWord[cfgSel] = 1'b1;
  end

  assign fire1       = !clear && !flag1Q && hit1;
  assign fire2       = !clear && flag1Q && !flag2Q && hit2;
  assign ctl.promote = fire1;
  assign ctl.clrGate = clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      flag1Q <= 1'b0;
      flag2Q <= 1'b0;
      seenQ  <= 1'b0;
    end else begin
      if (fire1) flag1Q <= 1'b1;
      if (fire2) flag2Q <= 1'b1;
      if (gateOut) seenQ <= 1'b1;
    end
  end

  assign word1Hit = flag1Q;
  assign word2Hit = flag2Q;
  assign gateSeen = seenQ | gateOut;

  // R5
  order_chk: assert property (@(posedge clk) disable iff (rst)
    word2Hit |-> word1Hit);

  // R7
  sticky1_chk: assert property (@(posedge clk) disable iff (rst)
    (word1Hit && !clear) |=> word1Hit);

  // R9
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (gateSeen && !clear) |=> gateSeen);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!word1Hit && !word2Hit && !gateSeen));

  // R2
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.ldWord));
endmodule

// File: rtl/dual_pattern_trigger.sv
module dual_pattern_trigger
  import trig_pkg::*;
#(
  parameter int W        = 28,
  parameter int GATE_DLY = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] busIn,
  input  logic         trigEn,
  input  logic         cfgBit,
  input  logic         cfgShift,
  input  logic         cfgLoad,
  input  logic [2:0]   cfgSel,
  input  logic         clear,
  output logic         word1Hit,
  output logic         word2Hit,
  output logic         gateOut,
  output logic         gateSeen
);
  ctl_t ctl;
  logic hit1, hit2;

  trig_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgLoad  (cfgLoad),
    .cfgSel   (cfgSel),
    .clear    (clear),
    .hit1     (hit1),
    .hit2     (hit2),
    .gateOut  (gateOut),
    .ctl      (ctl),
    .word1Hit (word1Hit),
    .word2Hit (word2Hit),
    .gateSeen (gateSeen)
  );

  trig_datapath #(.W(W), .GATE_DLY(GATE_DLY)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .busIn    (busIn),
    .trigEn   (trigEn),
    .cfgBit   (cfgBit),
    .cfgShift (cfgShift),
    .ctl      (ctl),
    .hit1     (hit1),
    .hit2     (hit2),
    .gateOut  (gateOut)
  );
endmodule

// File: tb/sim_dual_pattern_trigger.sv
module sim_dual_pattern_trigger;
  localparam int W   = 28;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] busIn = '0;
  logic trigEn = 1'b0, cfgBit = 1'b0, cfgShift = 1'b0, cfgLoad = 1'b0, clear = 1'b0;
  logic [2:0] cfgSel = '0;
  logic word1Hit, word2Hit, gateOut, gateSeen;

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  dual_pattern_trigger #(.W(W), .GATE_DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .busIn(busIn), .trigEn(trigEn),
    .cfgBit(cfgBit), .cfgShift(cfgShift), .cfgLoad(cfgLoad), .cfgSel(cfgSel),
    .clear(clear), .word1Hit(word1Hit), .word2Hit(word2Hit),
    .gateOut(gateOut), .gateSeen(gateSeen)
  );

  // reference state built from the requirements
  logic [W-1:0] mSr;
  logic [W-1:0] mW [6];
  logic [W-1:0] mA2l, mA2m;
  bit mF1, mF2, mSeen;
  int mCnt;

  function automatic bit matchFn(logic [W-1:0] b, logic [W-1:0] l, logic [W-1:0] m);
    return (((b ^ l) & m) == '0);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic modelReset();
    mSr = '0; mA2l = '0; mA2m = '0;
    for (int i = 0; i < 6; i++) mW[i] = '0;
    mF1 = 0; mF2 = 0; mSeen = 0; mCnt = 0;
  endtask

  // one clock: compute expected next state, advance, compare at the falling edge
  task automatic tick();
    logic [W-1:0] nSr, nA2l, nA2m;
    logic [W-1:0] nW [6];
    bit h1, h2, gc, nF1, nF2, nSeen;
    int nCnt;
    nSr = cfgShift ? {mSr[W-2:0], cfgBit} : mSr;
    for (int i = 0; i < 6; i++) nW[i] = mW[i];
    if (cfgLoad && cfgSel < 3'd6) nW[cfgSel] = mSr;
    h1 = trigEn && matchFn(busIn, mW[0], mW[1]);
    h2 = trigEn && matchFn(busIn, mA2l, mA2m);
    gc = matchFn(busIn, mW[4], mW[5]);
    nA2l = mA2l; nA2m = mA2m;
    nF1 = mF1; nF2 = mF2; nSeen = mSeen; nCnt = mCnt;
    if (clear) begin
      nF1 = 0; nF2 = 0; nSeen = 0; nCnt = 0;
    end else begin
      if (!mF1 && h1) begin nF1 = 1; nA2l = mW[2]; nA2m = mW[3]; end
      if (mF1 && h2) nF2 = 1;
      if (mCnt >= DLY) nSeen = 1;
      nCnt = gc ? ((mCnt < DLY) ? mCnt + 1 : DLY) : 0;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    mSr = nSr; mA2l = nA2l; mA2m = nA2m;
    for (int i = 0; i < 6; i++) mW[i] = nW[i];
    mF1 = nF1; mF2 = nF2; mSeen = nSeen; mCnt = nCnt;
    chk("R3 word1Hit", word1Hit, mF1);
    chk("R5 word2Hit", word2Hit, mF2);
    chk("R8 gateOut", gateOut, mCnt >= DLY);
    chk("R9 gateSeen", gateSeen, mSeen || (mCnt >= DLY));
  endtask

  task automatic loadWord(logic [2:0] sel, logic [W-1:0] val);
    for (int i = W - 1; i >= 0; i--) begin
      cfgBit = val[i]; cfgShift = 1; tick();
    end
    cfgShift = 0; cfgLoad = 1; cfgSel = sel; tick();
    cfgLoad = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int mode;
    logic [31:0] r;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 word1Hit", word1Hit, 0);
    chk("R1 word2Hit", word2Hit, 0);
    chk("R1 gateOut", gateOut, 0);
    chk("R1 gateSeen", gateSeen, 0);

    // R2: configure words through the serial stream
    loadWord(3'd4, 28'h8000000);
    loadWord(3'd5, 28'h8000000);
    loadWord(3'd0, 28'h00000F3);
    loadWord(3'd1, 28'h00000FF);
    loadWord(3'd2, 28'h1234567);
    loadWord(3'd3, 28'hFFFFFFF);
    clear = 1; tick(); clear = 0;

    // R4: enable low blocks stage 1
    trigEn = 0; busIn = 28'h00005F3; tick();
    chk("R4 word1Hit with enable low", word1Hit, 0);
    // R5: stage-2 pattern before stage 1 fired
    trigEn = 1; busIn = 28'h1234567; tick();
    chk("R5 word2Hit before word1", word2Hit, 0);
    // R3: masked stage-1 match
    busIn = 28'h00005F3; tick();
    chk("R3 word1Hit on masked match", word1Hit, 1);
    // R4: enable low blocks stage 2
    trigEn = 0; busIn = 28'h1234567; tick();
    chk("R4 word2Hit with enable low", word2Hit, 0);
    // R6: new holding word after stage 1 has no effect
    trigEn = 1; busIn = '0;
    loadWord(3'd2, 28'h0000001);
    busIn = 28'h0000001; tick();
    chk("R6 word2Hit on late-loaded word", word2Hit, 0);
    busIn = 28'h1234567; tick();
    chk("R5 word2Hit after word1", word2Hit, 1);
    // R10: clear beats a concurrent stage-1 match
    busIn = 28'h00005F3; clear = 1; tick(); clear = 0;
    chk("R10 word1Hit after clear", word1Hit, 0);
    chk("R10 word2Hit after clear", word2Hit, 0);
    // R7: re-armed after clear; R6: new holding word now active
    tick();
    chk("R7 word1Hit rearmed", word1Hit, 1);
    busIn = 28'h0000001; tick();
    chk("R6 word2Hit on promoted word", word2Hit, 1);
    // R2: unused select code changes nothing
    busIn = '0;
    loadWord(3'd6, 28'hFFFFFFF);
    clear = 1; tick(); clear = 0;
    busIn = 28'h00005F3; tick();
    chk("R2 select 6 ignored", word1Hit, 1);

    // R8: gate opens exactly after DLY qualifying edges
    busIn = 28'h0000000; clear = 1; tick(); clear = 0;
    busIn = 28'h8000000;
    for (int i = 0; i < DLY - 1; i++) tick();
    chk("R8 gate still closed", gateOut, 0);
    tick();
    chk("R8 gate open", gateOut, 1);
    chk("R9 gateSeen with gate", gateSeen, 1);
    busIn = 28'h0000000; tick();
    chk("R8 gate closes", gateOut, 0);
    chk("R9 gateSeen sticky", gateSeen, 1);
    clear = 1; tick(); clear = 0;
    chk("R10 gateSeen cleared", gateSeen, 0);

    // constrained random phase
    mode = 0;
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      if (n % 16 == 0) mode = int'($urandom % 4);
      case (mode)
        0: busIn = W'($urandom);
        1: busIn = mW[0] ^ (W'($urandom) & ~mW[1]);
        2: busIn = mA2l ^ (W'($urandom) & ~mA2m);
        default: busIn = mW[4] ^ (W'($urandom) & ~mW[5] & {W{r[20]}});
      endcase
      trigEn = (r[2:0] != 3'd0);
      clear = (r[15:8] < 8'd4);
      cfgShift = r[16] & r[17];
      cfgBit = r[18];
      cfgLoad = (r[31:24] < 8'd3);
      cfgSel = r[23:21];
      if (n % 500 == 250) begin
        cfgShift = 0; cfgLoad = 0; clear = 0;
        loadWord(3'(n % 6), W'($urandom) & W'($urandom));
      end else begin
        tick();
      end
    end
    cfgShift = 0; cfgLoad = 0; clear = 0;
    tick();
    finishRun();
  end
endmodule